// File: doc/BRIEF.md
# Byte-Stuffed Frame Transmit Encoder

The encoder turns an outgoing payload into a framed and escaped byte stream for a serial link. The payload arrives as a byte stream with valid/ready handshaking and first/last markers. The output is a byte stream with its own valid/ready handshake, built in this order:

- an opening delimiter;
- a zero header byte;
- the payload;
- the inverted 16-bit CRC of the header and payload, low byte first;
- a closing delimiter.

Any byte between the delimiters that could be mistaken for framing is replaced by a two-byte escape pair. While the second byte of a pair is on the output, the encoder holds off the input.

The datapath has no pipeline register. Payload bytes pass from input to output in the same cycle, and output backpressure reaches input ready in the same cycle. Only the escape byte, the CRC and the frame state are held in flops. The block is meant to sit between a framing-agnostic packet source and a byte-wide serial transmitter.

Top module: `frame_stuff_tx`

## Requirements
- R1: After reset, with no input offered, m_valid_o, frame_done_o and s_ready_o are low.
- R2: A frame opens with the byte 0x7E, never escaped, followed by a header byte 0x00. The frame starts when a byte with s_first_i high is offered while the encoder is idle.
- R3: Payload bytes other than 0x7E and 0x7D appear on the output unchanged and in input order.
- R4: Any byte between the delimiters equal to 0x7E is sent as 0x7D 0x5E. Any such byte equal to 0x7D is sent as 0x7D 0x5D. In both cases the second byte is the original XOR 0x20.
- R5: After the payload (the byte with s_last_i high ends it), the encoder sends a CRC. The CRC uses the reflected polynomial 0x8408, shifts least-significant bit first and starts from 0xFFFF. It covers the header byte and the payload before escaping. The final value is bit-inverted and sent low byte first, then high byte.
- R6: The two CRC bytes are escaped by the same rule as payload bytes.
- R7: The frame closes with the byte 0x7E, never escaped.
- R8: In the cycle after the first byte of an escape pair is accepted, s_ready_o is low and m_valid_o is high.
- R9: With m_ready_i held low, the output byte is held and no input byte is accepted. The encoded stream is identical under any pattern of output stalls and input gaps.
- R10: frame_done_o is high for exactly the one cycle after the closing delimiter is accepted.
- R11: While idle, a byte offered with s_first_i low is accepted (s_ready_o high) and discarded, and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_valid_i | input | 1 | Input byte valid |
| s_data_i | input | 8 | Input payload byte |
| s_first_i | input | 1 | Input byte is first of payload |
| s_last_i | input | 1 | Input byte is last of payload |
| s_ready_o | output | 1 | Input byte accepted this cycle when valid |
| m_valid_o | output | 1 | Output byte valid |
| m_data_o | output | 8 | Output encoded byte |
| m_ready_i | input | 1 | Downstream accepts output byte |
| frame_done_o | output | 1 | One-cycle pulse after closing delimiter |

## Verification
Output bytes depend combinationally on the current state and input, so each accepted byte is recorded at the falling edge before the edge that transfers it. R8 is due in the cycle right after the escape lead is accepted. frame_done_o is due one cycle after the closing delimiter is accepted (R10). The bench checks both at the falling edge that follows the relevant accept, never earlier. Whole frames are compared only once the full expected number of bytes has arrived, so stall patterns (R9) cannot shift a comparison.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 16;
  localparam logic [BYTE_W-1:0] DELIM_B = 8'h7E;
  localparam logic [BYTE_W-1:0] ESC_B   = 8'h7D;
  localparam logic [BYTE_W-1:0] XMASK_B = 8'h20;
  localparam logic [BYTE_W-1:0] HDR_B   = 8'h00;
  localparam logic [CRC_W-1:0]  CRC_POLY = 16'h8408;
  localparam logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_CRC_LO,
    ST_CRC_HI,
    ST_CLOSE
  } fs_state_e;
endpackage

// File: rtl/fs_crc16.sv
module fs_crc16 #(
  parameter int unsigned           DW   = fs_pkg::BYTE_W,
  parameter int unsigned           CW   = fs_pkg::CRC_W,
  parameter logic [CW-1:0]         POLY = fs_pkg::CRC_POLY,
  parameter logic [CW-1:0]         INIT = fs_pkg::CRC_INIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          upd_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  logic [CW-1:0] crc_q;
  logic [CW-1:0] chain [DW+1];

  // INIT is folded in when init_i and upd_i coincide
  assign chain[0] = (init_i ? INIT : crc_q) ^ {{(CW-DW){1'b0}}, data_i};

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign chain[b+1] = chain[b][0] ? ((chain[b] >> 1) ^ POLY) : (chain[b] >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= INIT;
    else if (upd_i)  crc_q <= chain[DW];
    else if (init_i) crc_q <= INIT;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/fs_seq.sv
module fs_seq
  import fs_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned CW = CRC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          s_valid_i,
  input  logic [DW-1:0] s_data_i,
  input  logic          s_first_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic          raw_valid_o,
  output logic [DW-1:0] raw_data_o,
  output logic          raw_delim_o,
  input  logic          raw_ready_i,
  input  logic [CW-1:0] crc_i,
  output logic          crc_init_o,
  output logic          crc_upd_o,
  output logic [DW-1:0] crc_data_o,
  output logic          done_o
);
  fs_state_e state_q, state_d;
  logic      take;
  logic      done_q;
  logic [CW-1:0] crc_inv;

  assign crc_inv = ~crc_i;
  assign take    = raw_valid_o && raw_ready_i;

  always_comb begin
    state_d     = state_q;
    raw_valid_o = 1'b0;
    raw_data_o  = HDR_B;
    raw_delim_o = 1'b0;
    s_ready_o   = 1'b0;
    crc_init_o  = 1'b0;
    crc_upd_o   = 1'b0;
    crc_data_o  = s_data_i;
    unique case (state_q)
      ST_IDLE: begin
        raw_valid_o = s_valid_i && s_first_i;
        raw_data_o  = DELIM_B;
        raw_delim_o = 1'b1;
        s_ready_o   = s_valid_i && !s_first_i;  // stray byte dropped
        if (take) begin
          crc_init_o = 1'b1;
          state_d    = ST_HDR;
        end
      end
      ST_HDR: begin
        raw_valid_o = 1'b1;
        raw_data_o  = HDR_B;
        crc_data_o  = HDR_B;
        if (take) begin
          crc_upd_o = 1'b1;
          state_d   = ST_PAY;
        end
      end
      ST_PAY: begin
        raw_valid_o = s_valid_i;
        raw_data_o  = s_data_i;
        s_ready_o   = raw_ready_i;
        if (take) begin
          crc_upd_o = 1'b1;
          if (s_last_i) state_d = ST_CRC_LO;
        end
      end
      ST_CRC_LO: begin
        raw_valid_o = 1'b1;
        raw_data_o  = crc_inv[DW-1:0];
        if (take) state_d = ST_CRC_HI;
      end
      ST_CRC_HI: begin
        raw_valid_o = 1'b1;
        raw_data_o  = crc_inv[CW-1:DW];
        if (take) state_d = ST_CLOSE;
      end
      ST_CLOSE: begin
        raw_valid_o = 1'b1;
        raw_data_o  = DELIM_B;
        raw_delim_o = 1'b1;
        if (take) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_CLOSE) && take;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/fs_stuff.sv
module fs_stuff
  import fs_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          raw_valid_i,
  input  logic [DW-1:0] raw_data_i,
  input  logic          raw_delim_i,
  output logic          raw_ready_o,
  output logic          m_valid_o,
  output logic [DW-1:0] m_data_o,
  input  logic          m_ready_i
);
  logic          pend_q;
  logic [DW-1:0] pend_byte_q;
  logic          hit;

  assign hit         = !raw_delim_i && (raw_data_i == DELIM_B || raw_data_i == ESC_B);
  assign raw_ready_o = !pend_q && m_ready_i;
  assign m_valid_o   = pend_q || raw_valid_i;
  assign m_data_o    = pend_q ? pend_byte_q : (hit ? ESC_B : raw_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
    end else if (pend_q) begin
      if (m_ready_i) pend_q <= 1'b0;
    end else if (raw_valid_i && raw_ready_o && hit) begin
      pend_q      <= 1'b1;
      pend_byte_q <= raw_data_i ^ XMASK_B;
    end
  end
endmodule

// File: rtl/frame_stuff_tx.sv
module frame_stuff_tx
  import fs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic             s_first_i,
  input  logic             s_last_i,
  output logic             s_ready_o,
  output logic             m_valid_o,
  output logic [BYTE_W-1:0] m_data_o,
  input  logic             m_ready_i,
  output logic             frame_done_o
);
  logic              raw_valid, raw_delim, raw_ready;
  logic [BYTE_W-1:0] raw_data, crc_data;
  logic              crc_init, crc_upd;
  logic [CRC_W-1:0]  crc;

  fs_seq #(.DW(BYTE_W), .CW(CRC_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s_valid_i   (s_valid_i),
    .s_data_i    (s_data_i),
    .s_first_i   (s_first_i),
    .s_last_i    (s_last_i),
    .s_ready_o   (s_ready_o),
    .raw_valid_o (raw_valid),
    .raw_data_o  (raw_data),
    .raw_delim_o (raw_delim),
    .raw_ready_i (raw_ready),
    .crc_i       (crc),
    .crc_init_o  (crc_init),
    .crc_upd_o   (crc_upd),
    .crc_data_o  (crc_data),
    .done_o      (frame_done_o)
  );

  fs_crc16 #(.DW(BYTE_W), .CW(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .upd_i  (crc_upd),
    .data_i (crc_data),
    .crc_o  (crc)
  );

  fs_stuff #(.DW(BYTE_W)) u_stuff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raw_valid_i (raw_valid),
    .raw_data_i  (raw_data),
    .raw_delim_i (raw_delim),
    .raw_ready_o (raw_ready),
    .m_valid_o   (m_valid_o),
    .m_data_o    (m_data_o),
    .m_ready_i   (m_ready_i)
  );
endmodule

// File: rtl/frame_stuff_tx_chk.sv
module frame_stuff_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       s_ready_o,
  input logic       m_valid_o,
  input logic [7:0] m_data_o,
  input logic       m_ready_i,
  input logic       frame_done_o
);
  logic acc;
  assign acc = m_valid_o && m_ready_i;

  // R4
  esc_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && m_data_o == 8'h7D) |=> (m_valid_o && (m_data_o == 8'h5E || m_data_o == 8'h5D)));

  // R8
  esc_hold_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && m_data_o == 8'h7D) |=> !s_ready_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R10
  done_after_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(acc && m_data_o == 8'h7E));
endmodule

bind frame_stuff_tx frame_stuff_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .s_ready_o    (s_ready_o),
  .m_valid_o    (m_valid_o),
  .m_data_o     (m_data_o),
  .m_ready_i    (m_ready_i),
  .frame_done_o (frame_done_o)
);

// File: tb/tb_frame_stuff_tx.sv
module tb_frame_stuff_tx;
  typedef logic [7:0] byte_q_t [$];

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       s_valid_i = 1'b0;
  logic [7:0] s_data_i = '0;
  logic       s_first_i = 1'b0;
  logic       s_last_i = 1'b0;
  logic       s_ready_o;
  logic       m_valid_o;
  logic [7:0] m_data_o;
  logic       m_ready_i = 1'b1;
  logic       frame_done_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rdy_mode = 0;
  int gap_mode = 0;
  bit running = 1'b1;
  byte_q_t obs;
  bit last_esc = 0, last_close = 0, in_frame = 0;

  frame_stuff_tx dut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic void put_stuffed(ref byte_q_t q, input logic [7:0] b);
    if (b == 8'h7E || b == 8'h7D) begin
      q.push_back(8'h7D);
      q.push_back(b ^ 8'h20);
    end else q.push_back(b);
  endfunction

  function automatic byte_q_t expect_frame(input byte_q_t pl);
    byte_q_t q;
    logic [15:0] c;
    c = crc_step(16'hFFFF, 8'h00);
    q.push_back(8'h7E);
    q.push_back(8'h00);
    foreach (pl[i]) begin
      c = crc_step(c, pl[i]);
      put_stuffed(q, pl[i]);
    end
    c = ~c;
    put_stuffed(q, c[7:0]);
    put_stuffed(q, c[15:8]);
    q.push_back(8'h7E);
    return q;
  endfunction

  // output ready pattern
  always @(posedge clk_i) begin
    #2;
    m_ready_i <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? ($urandom % 4 != 0) : ($urandom % 3 == 0);
  end

  // monitor, sampled away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && running) begin
      if (last_close || frame_done_o)
        chk(frame_done_o == last_close, "R10 frame_done", frame_done_o, last_close);
      if (last_esc) begin
        chk(!s_ready_o, "R8 s_ready during escape", s_ready_o, 0);
        chk(m_valid_o, "R8 m_valid during escape", m_valid_o, 1);
      end
      if (m_valid_o && m_ready_i) begin
        obs.push_back(m_data_o);
        last_esc   = (m_data_o == 8'h7D);
        last_close = (m_data_o == 8'h7E) && in_frame;
        if (m_data_o == 8'h7E) in_frame = !in_frame;
      end else begin
        last_esc   = 1'b0;
        last_close = 1'b0;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic send_frame(input byte_q_t pl, input string req);
    byte_q_t ex;
    bit ok;
    ex = expect_frame(pl);
    foreach (pl[i]) begin
      if (gap_mode != 0) begin
        int g = $urandom % 3;
        repeat (g) begin @(posedge clk_i); #2; end
      end
      s_valid_i = 1'b1;
      s_data_i  = pl[i];
      s_first_i = (i == 0);
      s_last_i  = (i == pl.size() - 1);
      forever begin
        @(negedge clk_i);
        if (s_ready_o) break;
      end
      @(posedge clk_i); #2;
      s_valid_i = 1'b0;
      s_first_i = 1'b0;
      s_last_i  = 1'b0;
    end
    while (obs.size() < ex.size()) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    ok = (obs.size() == ex.size());
    if (ok) foreach (ex[i]) if (obs[i] != ex[i]) ok = 0;
    if (!ok) foreach (ex[i]) if (i < obs.size() && obs[i] != ex[i])
      $display("  byte %0d got %0h want %0h", i, obs[i], ex[i]);
    chk(ok, req, obs.size(), ex.size());
    obs.delete();
  endtask

  initial begin
    byte_q_t pl;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(!m_valid_o, "R1 m_valid after reset", m_valid_o, 0);
    chk(!frame_done_o, "R1 frame_done after reset", frame_done_o, 0);
    chk(!s_ready_o, "R1 s_ready after reset", s_ready_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;

    // R2 R3 R5 R7: plain payload
    pl = {8'h01, 8'h02, 8'h03, 8'h41};
    send_frame(pl, "R2 R3 R5 R7 plain frame");
    // R5 single zero byte
    pl = {8'h00};
    send_frame(pl, "R5 single byte frame");
    // R4 escape bytes only
    pl = {8'h7E, 8'h7D, 8'h7E, 8'h7E, 8'h7D, 8'h5E};
    send_frame(pl, "R4 escape payload");

    // R6: search a payload whose CRC needs escaping
    begin
      bit found = 0;
      for (int v = 0; v < 65536 && !found; v++) begin
        logic [15:0] c;
        c = crc_step(crc_step(crc_step(16'hFFFF, 8'h00), v[7:0]), v[15:8]);
        c = ~c;
        if (c[7:0] == 8'h7E || c[7:0] == 8'h7D || c[15:8] == 8'h7E || c[15:8] == 8'h7D) begin
          pl = {v[7:0], v[15:8]};
          found = 1;
        end
      end
      chk(found, "R6 escaped CRC payload found", found, 1);
      send_frame(pl, "R6 escaped CRC bytes");
    end

    // R11 stray byte while idle
    rdy_mode = 0;
    @(posedge clk_i); #2;
    s_valid_i = 1'b1; s_first_i = 1'b0; s_data_i = 8'h7E;
    @(negedge clk_i);
    chk(s_ready_o, "R11 stray accepted", s_ready_o, 1);
    chk(!m_valid_o, "R11 stray no output", m_valid_o, 0);
    @(posedge clk_i); #2;
    s_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(obs.size() == 0, "R11 no bytes emitted", obs.size(), 0);
    obs.delete();
    @(posedge clk_i); #2;

    // R9: stalls and gaps, random payloads
    for (int f = 0; f < 40; f++) begin
      int n = 1 + $urandom % 12;
      rdy_mode = f % 3;
      gap_mode = f % 2;
      pl.delete();
      for (int i = 0; i < n; i++)
        pl.push_back(($urandom % 4 == 0) ? (($urandom % 2) ? 8'h7E : 8'h7D) : 8'($urandom));
      send_frame(pl, "R9 R3 R4 random frame under stalls");
    end

    running = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule